// File: doc/BRIEF.md
# DMA Channel Byte-Count Status Tracker

This block keeps the live status of one DMA channel that moves a buffer between a 32-bit system bus and a USB device endpoint. A descriptor load presets a 16-bit remaining-byte counter. Each finished bus address phase then lowers the counter by the number of bytes that phase carried. That is 1 to 4 bytes, and fewer than 4 only at an unaligned start or at the tail of the buffer. The counter never drops below zero: a tail phase removes only the bytes still owed.

Alongside the counter the block keeps two live flags, channel enabled and channel active. It also keeps three sticky event flags: descriptor loaded, buffer exhausted and transfer ended by the device. The sticky flags clear when software reads the status word. When software withdraws the enable while the channel FIFO still holds data, the enable flag stays up until the FIFO reports empty. When the enable drops and load-next is configured, the block raises a request for the next descriptor and holds it until a descriptor arrives.

Top module: `dma_chan_status`

## Requirements
- R1: After reset the status word and the next-descriptor request are all zero. Status word layout: remaining count in bits 31:16, descriptor-loaded in bit 6, buffer-exhausted in bit 5, device-ended in bit 4, active in bit 1, enabled in bit 0, other bits zero. Every status change appears one clock after the input that causes it.
- R2: A descriptor load writes the remaining count, sets the descriptor-loaded flag, and sets the enabled flag to the descriptor's enable bit.
- R3: A completed bus phase of width N (1..4) with at least N bytes owed lowers the count by exactly N.
- R4: A phase wider than the bytes still owed brings the count to zero and never wraps it.
- R5: The phase that brings a nonzero count to zero sets the buffer-exhausted flag and clears the enabled flag.
- R6: A device transfer-end indication sets the device-ended flag and clears both the enabled and active flags.
- R7: A status read clears the three sticky flags. If a flag's set event coincides with the read, the flag ends up set.
- R8: A software disable issued while the FIFO is not empty leaves the enabled flag set. The flag clears one clock after the FIFO reports empty.
- R9: A software disable issued while the FIFO is empty clears the enabled flag one clock later.
- R10: The active flag sets when a packet starts on an enabled channel and clears at packet end. A buffer-exhausted event does not clear it.
- R11: When the enabled flag falls and load-next is configured, the next-descriptor request rises in the same cycle. It holds until a descriptor load or a software enable. With load-next not configured, no request is raised.
- R12: A completed bus phase while the count is zero has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_en_set | input | 1 | Software enable pulse |
| sw_en_clr | input | 1 | Software disable pulse |
| ld_next_ctl | input | 1 | Load-next-descriptor configuration bit |
| dsc_load | input | 1 | Descriptor load completed (pulse) |
| dsc_count | input | 16 | Byte count carried by the descriptor |
| dsc_enable | input | 1 | Enable bit carried by the descriptor |
| bus_phase_done | input | 1 | A bus address phase has completed (pulse) |
| bus_phase_bytes | input | 3 | Byte width of the completed phase, 1..4 |
| dev_xfer_end | input | 1 | Device has ended the transfer and the last packet is complete |
| pkt_begin | input | 1 | Channel selected to source a packet |
| pkt_end | input | 1 | Packet transfer finished |
| fifo_empty | input | 1 | Channel FIFO holds no data |
| stat_rd | input | 1 | Software read of the status word (pulse) |
| stat_word | output | 32 | Packed status word |
| next_dsc_req | output | 1 | Request for the next descriptor |

## Verification
The assertions assume that a completed bus phase always reports a width between 1 and 4. They also assume that a packet start arrives only while the channel is enabled. The bench drives phase widths only inside that range and issues packet starts only after it has seen the enabled flag set. The count is sampled only while the active flag is low, or in a cycle where no phase completes, so every compared value is a settled one.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  // sticky flag indices
  localparam int unsigned FLAG_N    = 3;
  localparam int unsigned FIDX_DESC = 0;
  localparam int unsigned FIDX_EOB  = 1;
  localparam int unsigned FIDX_EOT  = 2;
  // status word bit positions (decoded by the register read path)
  localparam int unsigned POS_EN    = 0;
  localparam int unsigned POS_ACT   = 1;
  localparam int unsigned POS_EOT   = 4;
  localparam int unsigned POS_EOB   = 5;
  localparam int unsigned POS_DESC  = 6;
  localparam int unsigned POS_CNT   = 16;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dma_bytecnt.sv
module dma_bytecnt #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BUS_BYTES = 4,
  localparam int unsigned BW_W     = $clog2(BUS_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             phase_done,
  input  logic [BW_W-1:0]  phase_bytes,
  output logic [CNT_W-1:0] cnt_q,
  output logic             buf_end
);
  logic [CNT_W-1:0] bytes_ext;
  logic [CNT_W-1:0] take;
  logic [CNT_W-1:0] cnt_d;
  logic             owed;
  logic             cnt_en;

  always_comb begin
    bytes_ext = CNT_W'(phase_bytes);
    owed      = (cnt_q != '0);
    take      = (bytes_ext >= cnt_q) ? cnt_q : bytes_ext;
    buf_end   = phase_done && owed && (bytes_ext >= cnt_q) && !load;
    cnt_en    = load || (phase_done && owed);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // input assumption: phase width is legal
  assert_phase_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |-> (phase_bytes != '0) && (phase_bytes <= BW_W'(BUS_BYTES)));

  assert_exact_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_done && !load && (cnt_q >= CNT_W'(phase_bytes)))
      |=> cnt_q == $past(cnt_q) - CNT_W'($past(phase_bytes)));

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_done && !load) |=> cnt_q <= $past(cnt_q));

  assert_zero_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_done && !load && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/dma_sticky_flags.sv
module dma_sticky_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic         rd,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_d;
    logic f_en;

    always_comb begin
      f_en = set_ev[i] || rd;
      f_d  = set_ev[i];      // set beats the read clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag_q[i] <= 1'b0;
      else if (f_en) flag_q[i] <= f_d;
    end

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !set_ev[i]) |=> !flag_q[i]);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flag_q[i]);
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_en_set,
  input  logic sw_en_clr,
  input  logic ld_next,
  input  logic desc_load,
  input  logic desc_enable,
  input  logic buf_end,
  input  logic dev_end,
  input  logic fifo_empty,
  input  logic pkt_start,
  input  logic pkt_done,
  output logic en_q,
  output logic act_q,
  output logic req_q
);
  logic drain_q, drain_d;
  logic en_d, act_d, req_d;
  logic turn_on, turn_off_now, xfer_over, en_fall;

  always_comb begin
    turn_on      = sw_en_set || (desc_load && desc_enable);
    xfer_over    = buf_end || dev_end;
    turn_off_now = (sw_en_clr && fifo_empty) || (drain_q && fifo_empty);

    // enable flag
    if (turn_on)                        en_d = 1'b1;
    else if (desc_load)                 en_d = 1'b0;
    else if (xfer_over || turn_off_now) en_d = 1'b0;
    else                                en_d = en_q;

    // pending disable waiting on FIFO drain
    if (turn_on || desc_load || xfer_over) drain_d = 1'b0;
    else if (sw_en_clr && en_q && !fifo_empty) drain_d = 1'b1;
    else if (fifo_empty)                 drain_d = 1'b0;
    else                                 drain_d = drain_q;

    // active flag: end of buffer alone does not drop it
    if (pkt_done || dev_end)    act_d = 1'b0;
    else if (pkt_start && en_q) act_d = 1'b1;
    else                        act_d = act_q;

    // next-descriptor request
    en_fall = en_q && !en_d;
    if (desc_load || turn_on)   req_d = 1'b0;
    else if (en_fall && ld_next) req_d = 1'b1;
    else                        req_d = req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      drain_q <= 1'b0;
      act_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      drain_q <= drain_d;
      act_q   <= act_d;
      req_q   <= req_d;
    end
  end

  // input assumption: packets start only on an enabled channel
  assert_pkt_when_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> en_q);

  assert_drain_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && drain_q && !fifo_empty && !xfer_over && !desc_load)
      |=> en_q);

  assert_end_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_end && !turn_on) |=> !en_q);

  assert_dev_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_end && !turn_on) |=> (!en_q && !act_q));

  assert_eob_keeps_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && buf_end && !pkt_done && !dev_end) |=> act_q);

  assert_req_only_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !en_q);
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_stat_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BUS_BYTES = 4,
  localparam int unsigned BW_W     = $clog2(BUS_BYTES) + 1,
  localparam int unsigned STAT_W   = POS_CNT + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en_set,
  input  logic              sw_en_clr,
  input  logic              ld_next_ctl,
  input  logic              dsc_load,
  input  logic [CNT_W-1:0]  dsc_count,
  input  logic              dsc_enable,
  input  logic              bus_phase_done,
  input  logic [BW_W-1:0]   bus_phase_bytes,
  input  logic              dev_xfer_end,
  input  logic              pkt_begin,
  input  logic              pkt_end,
  input  logic              fifo_empty,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_word,
  output logic              next_dsc_req
);
  logic              srst_n;
  logic [CNT_W-1:0]  cnt_q;
  logic              buf_end;
  logic [FLAG_N-1:0] set_ev;
  logic [FLAG_N-1:0] flags;
  logic              en_q, act_q;

  dma_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dma_bytecnt #(.CNT_W(CNT_W), .BUS_BYTES(BUS_BYTES)) u_cnt (
    .clk         (clk),
    .rst_n       (srst_n),
    .load        (dsc_load),
    .load_val    (dsc_count),
    .phase_done  (bus_phase_done),
    .phase_bytes (bus_phase_bytes),
    .cnt_q       (cnt_q),
    .buf_end     (buf_end)
  );

  always_comb begin
    set_ev            = '0;
    set_ev[FIDX_DESC] = dsc_load;
    set_ev[FIDX_EOB]  = buf_end;
    set_ev[FIDX_EOT]  = dev_xfer_end;
  end

  dma_sticky_flags #(.N(FLAG_N)) u_flags (
    .clk    (clk),
    .rst_n  (srst_n),
    .set_ev (set_ev),
    .rd     (stat_rd),
    .flag_q (flags)
  );

  dma_chan_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (srst_n),
    .sw_en_set   (sw_en_set),
    .sw_en_clr   (sw_en_clr),
    .ld_next     (ld_next_ctl),
    .desc_load   (dsc_load),
    .desc_enable (dsc_enable),
    .buf_end     (buf_end),
    .dev_end     (dev_xfer_end),
    .fifo_empty  (fifo_empty),
    .pkt_start   (pkt_begin),
    .pkt_done    (pkt_end),
    .en_q        (en_q),
    .act_q       (act_q),
    .req_q       (next_dsc_req)
  );

  always_comb begin
    stat_word                     = '0;
    stat_word[POS_CNT +: CNT_W]   = cnt_q;
    stat_word[POS_DESC]           = flags[FIDX_DESC];
    stat_word[POS_EOB]            = flags[FIDX_EOB];
    stat_word[POS_EOT]            = flags[FIDX_EOT];
    stat_word[POS_ACT]            = act_q;
    stat_word[POS_EN]             = en_q;
  end

  assert_load_flag_R2: assert property (@(posedge clk) disable iff (!srst_n)
    dsc_load |=> (stat_word[POS_DESC] && stat_word[POS_CNT +: CNT_W] == $past(dsc_count)));
endmodule

// File: tb/dma_chan_status_bench.sv
module dma_chan_status_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_en_set, sw_en_clr, ld_next_ctl, dsc_load, dsc_enable;
  logic [15:0] dsc_count;
  logic        bus_phase_done;
  logic [2:0]  bus_phase_bytes;
  logic        dev_xfer_end, pkt_begin, pkt_end, fifo_empty, stat_rd;
  logic [31:0] stat_word;
  logic        next_dsc_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_status u_dma_chan_status (
    .clk(clk), .rst_n(rst_n), .sw_en_set(sw_en_set), .sw_en_clr(sw_en_clr),
    .ld_next_ctl(ld_next_ctl), .dsc_load(dsc_load), .dsc_count(dsc_count),
    .dsc_enable(dsc_enable), .bus_phase_done(bus_phase_done),
    .bus_phase_bytes(bus_phase_bytes), .dev_xfer_end(dev_xfer_end),
    .pkt_begin(pkt_begin), .pkt_end(pkt_end), .fifo_empty(fifo_empty),
    .stat_rd(stat_rd), .stat_word(stat_word), .next_dsc_req(next_dsc_req)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cnt();  return {16'h0, stat_word[31:16]}; endfunction
  function automatic logic [31:0] fl(int b); return {31'h0, stat_word[b]}; endfunction

  task automatic idle();
    sw_en_set = 0; sw_en_clr = 0; dsc_load = 0; dsc_enable = 0; dsc_count = 0;
    bus_phase_done = 0; bus_phase_bytes = 3'd1; dev_xfer_end = 0;
    pkt_begin = 0; pkt_end = 0; stat_rd = 0;
  endtask

  task automatic load(logic [15:0] c, logic en);
    dsc_load = 1; dsc_count = c; dsc_enable = en; tick(); idle();
  endtask

  task automatic phase(logic [2:0] n);
    bus_phase_done = 1; bus_phase_bytes = n; tick(); idle();
  endtask

  task automatic rd();
    stat_rd = 1; tick(); idle();
  endtask

  task automatic t_reset();
    chk("R1", "status word", stat_word, 32'h0);
    chk("R1", "next request", {31'h0, next_dsc_req}, 32'h0);
  endtask

  task automatic t_load_and_count();
    load(16'd10, 1'b1);
    chk("R2", "count", cnt(), 32'd10);
    chk("R2", "desc flag", fl(6), 1);
    chk("R2", "enabled", fl(0), 1);
    phase(3'd3);
    chk("R3", "count after 3", cnt(), 32'd7);
    phase(3'd4);
    chk("R3", "count after 4", cnt(), 32'd3);
    phase(3'd4);
    chk("R4", "tail saturates", cnt(), 32'd0);
    chk("R5", "eob flag", fl(5), 1);
    chk("R5", "enable cleared", fl(0), 0);
    chk("R11", "no req without ld_next", {31'h0, next_dsc_req}, 0);
  endtask

  task automatic t_read_clear();
    rd();
    chk("R7", "desc cleared", fl(6), 0);
    chk("R7", "eob cleared", fl(5), 0);
    stat_rd = 1; dsc_load = 1; dsc_count = 16'd2; dsc_enable = 1; tick(); idle();
    chk("R7", "set wins over read", fl(6), 1);
    chk("R2", "count 2", cnt(), 32'd2);
  endtask

  task automatic t_zero_phase();
    phase(3'd2);
    chk("R5", "exact end count", cnt(), 0);
    phase(3'd4);
    chk("R12", "count stays zero", cnt(), 0);
    chk("R12", "enable stays off", fl(0), 0);
  endtask

  task automatic t_dev_end();
    rd();
    load(16'd100, 1'b1);
    pkt_begin = 1; tick(); idle();
    chk("R10", "active set", fl(1), 1);
    pkt_end = 1; tick(); idle();
    chk("R10", "active cleared", fl(1), 0);
    chk("R3", "count unchanged", cnt(), 32'd100);
    pkt_begin = 1; tick(); idle();
    dev_xfer_end = 1; tick(); idle();
    chk("R6", "eot flag", fl(4), 1);
    chk("R6", "enable cleared", fl(0), 0);
    chk("R6", "active cleared", fl(1), 0);
  endtask

  task automatic t_drain();
    fifo_empty = 0;
    sw_en_set = 1; tick(); idle();
    chk("R8", "enabled", fl(0), 1);
    sw_en_clr = 1; tick(); idle();
    chk("R8", "held while draining", fl(0), 1);
    tick(); tick(); tick();
    chk("R8", "still held", fl(0), 1);
    fifo_empty = 1; tick();
    chk("R8", "cleared after drain", fl(0), 0);
  endtask

  task automatic t_quick_off();
    sw_en_set = 1; tick(); idle();
    sw_en_clr = 1; tick(); idle();
    chk("R9", "cleared at once", fl(0), 0);
    chk("R11", "no req, ld_next off", {31'h0, next_dsc_req}, 0);
  endtask

  task automatic t_next_req();
    ld_next_ctl = 1;
    sw_en_set = 1; tick(); idle();
    chk("R11", "req idle while enabled", {31'h0, next_dsc_req}, 0);
    sw_en_clr = 1; tick(); idle();
    chk("R11", "enable off", fl(0), 0);
    chk("R11", "req raised", {31'h0, next_dsc_req}, 1);
    tick();
    chk("R11", "req held", {31'h0, next_dsc_req}, 1);
    load(16'd8, 1'b0);
    chk("R11", "req dropped by load", {31'h0, next_dsc_req}, 0);
    ld_next_ctl = 0;
  endtask

  task automatic t_eob_active();
    rd();
    load(16'd4, 1'b1);
    pkt_begin = 1; tick(); idle();
    stat_rd = 1; bus_phase_done = 1; bus_phase_bytes = 3'd4; tick(); idle();
    chk("R7", "eob set beats read", fl(5), 1);
    chk("R10", "active survives eob", fl(1), 1);
    chk("R5", "enable off", fl(0), 0);
    pkt_end = 1; tick(); idle();
    chk("R10", "active off at pkt end", fl(1), 0);
    chk("R4", "count zero", cnt(), 0);
  endtask

  initial begin
    idle(); ld_next_ctl = 0; fifo_empty = 1;
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    t_reset();
    t_load_and_count();
    t_read_clear();
    t_zero_phase();
    t_dev_end();
    t_drain();
    t_quick_off();
    t_next_req();
    t_eob_active();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule